// File: doc/BRIEF.md
# Four-Line Victim Store

This block is a small, fully associative holding area placed next to a main cache. When the main cache has to evict a two-word block, it pushes the block in here together with its tag and a valid bit for each word. Only after a main-cache miss is the store asked about an address. The tag is then compared against every line at the same time, and in the same cycle the block answers with a hit flag, the addressed word and the whole block. On a hit the main cache may pull the block back. Asserting the removal strobe during that lookup clears the line, so the block never sits in both places at once.

Write-through stores are also presented to the block. A store whose tag matches a held line updates the addressed word in place, so the victim copy stays coherent with memory. Replacement is strict first-in first-out. A round-robin pointer names the next line to fill, and it moves on with every insertion, so once all lines are full the oldest insertion is the one lost. One instance serves the instruction side and another the data side.

Top module: `victim_store`

## Requirements
- R1: After reset every line is empty, so a lookup of any address reports no hit.
- R2: The address is split into a tag and a word select. The word select is bit 0: 0 selects word 0 and 1 selects word 1. The tag is the bits above bit 0. `lk_hit` is 1 in the same cycle only when `lk_en` is 1, a line holds that tag with at least one valid word, and the selected word's valid bit is set. `lk_word` then carries that word.
- R3: An insertion writes the tag, both words and the two valid bits into one line. Valid bit 0 belongs to word 0 and valid bit 1 to word 1. The new contents are visible to lookups from the next cycle on.
- R4: Insertions fill lines 0, 1, 2, 3 in turn and then wrap. The fifth insertion replaces the block that was inserted first.
- R5: On a hit, `lk_blk0`, `lk_blk1` and `lk_bvalid` return the whole matching block and its valid bits, so the block can go back to the main cache.
- R6: If `rm_en` is 1 while a lookup hits, the hitting line is empty from the next cycle. If `rm_en` is 1 during a lookup that misses, no line changes.
- R7: A store (`st_en`) whose tag matches a line holding any valid word writes `st_word` into the selected word and sets that word's valid bit. A store that matches no line changes nothing.
- R8: When an insertion targets the same line that a removal or store hits in the same cycle, the insertion wins.
- R9: When `lk_en` is 0, or when a lookup misses, `lk_hit` is 0 and every data and valid output is 0.
- R10: The fill pointer advances on every insertion even if an earlier line has been emptied by removal. Emptied lines are refilled only when the pointer reaches them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_en | input | 1 | Insert an evicted block |
| ins_tag | input | TAG_W | Tag of the inserted block |
| ins_word0 | input | DATA_W | Word 0 of the inserted block |
| ins_word1 | input | DATA_W | Word 1 of the inserted block |
| ins_wvalid | input | 2 | Per-word valid bits of the inserted block |
| lk_en | input | 1 | Probe request, raised on a main-cache miss |
| lk_addr | input | TAG_W+1 | Probe word address (tag above bit 0, word select in bit 0) |
| rm_en | input | 1 | Remove the hitting line at the end of this cycle |
| st_en | input | 1 | Write-through store is present |
| st_addr | input | TAG_W+1 | Store word address |
| st_word | input | DATA_W | Store data |
| lk_hit | output | 1 | Probe hit |
| lk_word | output | DATA_W | Addressed word on a hit |
| lk_blk0 | output | DATA_W | Word 0 of the hitting block |
| lk_blk1 | output | DATA_W | Word 1 of the hitting block |
| lk_bvalid | output | 2 | Valid bits of the hitting block |

## Verification
The bench builds the store with four lines, a 4-bit tag and 16-bit words. With those values the whole address space is only 32 word addresses. After each insertion, removal, store or collision, the bench probes every one of those addresses and compares all outputs against the expected state of each line. That makes partially valid blocks, wrap-around of the fill pointer, holes left by removal and same-cycle insert/remove collisions visible across every tag, not just the tags the stimulus touched.

// File: rtl/vcache_pkg.sv
`timescale 1ns/1ps
package vcache_pkg;
  localparam int unsigned BLK_WORDS = 2;
  typedef logic [BLK_WORDS-1:0] wmask_t;
endpackage

// File: rtl/vcache_repl.sv
`timescale 1ns/1ps
module vcache_repl #(
  parameter int unsigned LINES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [LINES-1:0] fill_sel
);
  localparam int unsigned PTR_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(LINES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv) begin
      if (ptr_q == LAST) ptr_d = '0;
      else               ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr_q <= '0;
    else if (adv) ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < LINES; i++) begin : g_sel
    assign fill_sel[i] = (ptr_q == PTR_W'(i));
  end

  p_ptr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));
  p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == LAST) |=> ptr_q == '0);
endmodule

// File: rtl/vcache_match.sv
`timescale 1ns/1ps
module vcache_match #(
  parameter int unsigned LINES = 4,
  parameter int unsigned TAG_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LINES-1:0][TAG_W-1:0] line_tag,
  input  logic [LINES-1:0]            line_live,
  input  logic [TAG_W-1:0]            probe_tag,
  output logic [LINES-1:0]            match
);
  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign match[i] = line_live[i] && (line_tag[i] == probe_tag);
  end

  // a tag is held by at most one line (R2)
  p_single_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
endmodule

// File: rtl/vcache_lines.sv
`timescale 1ns/1ps
module vcache_lines
  import vcache_pkg::*;
#(
  parameter int unsigned LINES  = 4,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic [LINES-1:0]                           ins_sel,
  input  logic [TAG_W-1:0]                           ins_tag,
  input  logic [BLK_WORDS-1:0][DATA_W-1:0]           ins_blk,
  input  wmask_t                                     ins_vld,
  input  logic [LINES-1:0]                           rm_sel,
  input  logic [LINES-1:0]                           st_sel,
  input  logic                                       st_w,
  input  logic [DATA_W-1:0]                          st_data,
  output logic [LINES-1:0][TAG_W-1:0]                tag_o,
  output logic [LINES-1:0][BLK_WORDS-1:0][DATA_W-1:0] dat_o,
  output wmask_t [LINES-1:0]                         vld_o
);
  logic [LINES-1:0][TAG_W-1:0]                 tag_q, tag_d;
  logic [LINES-1:0][BLK_WORDS-1:0][DATA_W-1:0] dat_q, dat_d;
  wmask_t [LINES-1:0]                          vld_q, vld_d;
  logic [LINES-1:0]                            line_we;

  always_comb begin
    tag_d = tag_q;
    dat_d = dat_q;
    vld_d = vld_q;
    for (int i = 0; i < LINES; i++) begin
      if (ins_sel[i]) begin
        tag_d[i] = ins_tag;
        dat_d[i] = ins_blk;
        vld_d[i] = ins_vld;
      end else if (rm_sel[i]) begin
        vld_d[i] = '0;
      end else if (st_sel[i]) begin
        dat_d[i][st_w] = st_data;
        vld_d[i][st_w] = 1'b1;
      end
    end
  end

  assign line_we = ins_sel | rm_sel | st_sel;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          vld_q[i] <= '0;
      else if (line_we[i]) vld_q[i] <= vld_d[i];
    end

    always_ff @(posedge clk) begin
      if (line_we[i]) begin
        tag_q[i] <= tag_d[i];
        dat_q[i] <= dat_d[i];
      end
    end

    p_insert_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ins_sel[i] |=> (tag_q[i] == $past(ins_tag)) && (vld_q[i] == $past(ins_vld))
                     && (dat_q[i] == $past(ins_blk)));
    p_remove_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rm_sel[i] && !ins_sel[i]) |=> vld_q[i] == '0);
    p_store_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_sel[i] && !ins_sel[i] && !rm_sel[i])
        |=> (dat_q[i][$past(st_w)] == $past(st_data)) && vld_q[i][$past(st_w)]);
    p_insert_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_sel[i] && (rm_sel[i] || st_sel[i])) |=> vld_q[i] == $past(ins_vld));
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !line_we[i] |=> $stable(vld_q[i]));
  end

  assign tag_o = tag_q;
  assign dat_o = dat_q;
  assign vld_o = vld_q;
endmodule

// File: rtl/victim_store.sv
`timescale 1ns/1ps
module victim_store
  import vcache_pkg::*;
#(
  parameter int unsigned LINES  = 4,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W = TAG_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_en,
  input  logic [TAG_W-1:0]  ins_tag,
  input  logic [DATA_W-1:0] ins_word0,
  input  logic [DATA_W-1:0] ins_word1,
  input  logic [1:0]        ins_wvalid,
  input  logic              lk_en,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              rm_en,
  input  logic              st_en,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_word,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_word,
  output logic [DATA_W-1:0] lk_blk0,
  output logic [DATA_W-1:0] lk_blk1,
  output logic [1:0]        lk_bvalid
);
  logic [LINES-1:0][TAG_W-1:0]                 tag_w;
  logic [LINES-1:0][BLK_WORDS-1:0][DATA_W-1:0] dat_w;
  wmask_t [LINES-1:0]                          vld_w;
  logic [LINES-1:0] live, lk_match, st_match, line_hit, fill_sel;
  logic [LINES-1:0] ins_sel, rm_sel, st_sel;
  logic             lk_ws;

  assign lk_ws = lk_addr[0];

  for (genvar i = 0; i < LINES; i++) begin : g_live
    assign live[i]     = |vld_w[i];
    assign line_hit[i] = lk_en && lk_match[i] && vld_w[i][lk_ws];
  end

  assign ins_sel = ins_en ? fill_sel : '0;
  assign rm_sel  = rm_en  ? line_hit : '0;
  assign st_sel  = st_en  ? st_match : '0;

  vcache_repl #(.LINES(LINES)) u_repl (
    .clk(clk), .rst_n(rst_n), .adv(ins_en), .fill_sel(fill_sel)
  );

  vcache_match #(.LINES(LINES), .TAG_W(TAG_W)) u_lk_match (
    .clk(clk), .rst_n(rst_n), .line_tag(tag_w), .line_live(live),
    .probe_tag(lk_addr[ADDR_W-1:1]), .match(lk_match)
  );

  vcache_match #(.LINES(LINES), .TAG_W(TAG_W)) u_st_match (
    .clk(clk), .rst_n(rst_n), .line_tag(tag_w), .line_live(live),
    .probe_tag(st_addr[ADDR_W-1:1]), .match(st_match)
  );

  vcache_lines #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .ins_sel(ins_sel), .ins_tag(ins_tag), .ins_blk({ins_word1, ins_word0}),
    .ins_vld(ins_wvalid),
    .rm_sel(rm_sel), .st_sel(st_sel), .st_w(st_addr[0]), .st_data(st_word),
    .tag_o(tag_w), .dat_o(dat_w), .vld_o(vld_w)
  );

  always_comb begin
    lk_hit    = 1'b0;
    lk_word   = '0;
    lk_blk0   = '0;
    lk_blk1   = '0;
    lk_bvalid = '0;
    for (int i = 0; i < LINES; i++) begin
      if (line_hit[i]) begin
        lk_hit    = 1'b1;
        lk_word   = lk_word   | dat_w[i][lk_ws];
        lk_blk0   = lk_blk0   | dat_w[i][0];
        lk_blk1   = lk_blk1   | dat_w[i][1];
        lk_bvalid = lk_bvalid | vld_w[i];
      end
    end
  end

  p_hit_word_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_bvalid[lk_addr[0]]);
  p_hit_word_agrees_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_word == (lk_addr[0] ? lk_blk1 : lk_blk0));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_en |-> !lk_hit && lk_word == '0 && lk_bvalid == '0);
  p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> lk_blk0 == '0 && lk_blk1 == '0);
  p_remove_gone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rm_en && lk_hit && !ins_en && !st_en) |=> !(lk_en && lk_addr == $past(lk_addr)) || !lk_hit);
endmodule

// File: tb/victim_store_bench.sv
`timescale 1ns/1ps
module victim_store_bench;
  localparam int LINES = 4, TAG_W = 4, DATA_W = 16, ADDR_W = TAG_W + 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_en = 0, lk_en = 0, rm_en = 0, st_en = 0;
  logic [TAG_W-1:0] ins_tag = '0;
  logic [DATA_W-1:0] ins_word0 = '0, ins_word1 = '0, st_word = '0;
  logic [1:0] ins_wvalid = '0;
  logic [ADDR_W-1:0] lk_addr = '0, st_addr = '0;
  logic lk_hit;
  logic [DATA_W-1:0] lk_word, lk_blk0, lk_blk1;
  logic [1:0] lk_bvalid;

  int total = 0, bad = 0;
  bit done = 0;

  logic [TAG_W-1:0]  m_tag [LINES];
  logic [1:0]        m_vld [LINES];
  logic [DATA_W-1:0] m_d0  [LINES];
  logic [DATA_W-1:0] m_d1  [LINES];
  int                m_ptr;

  always #2.5 clk = ~clk;

  victim_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_victim_store (
    .clk(clk), .rst_n(rst_n), .ins_en(ins_en), .ins_tag(ins_tag),
    .ins_word0(ins_word0), .ins_word1(ins_word1), .ins_wvalid(ins_wvalid),
    .lk_en(lk_en), .lk_addr(lk_addr), .rm_en(rm_en), .st_en(st_en),
    .st_addr(st_addr), .st_word(st_word), .lk_hit(lk_hit), .lk_word(lk_word),
    .lk_blk0(lk_blk0), .lk_blk1(lk_blk1), .lk_bvalid(lk_bvalid)
  );

  function automatic logic [DATA_W-1:0] pat(input int tag, input int w);
    return DATA_W'(tag * 257 + w * 4099 + 16'h0A05);
  endfunction

  function automatic int find(input logic [TAG_W-1:0] t);
    for (int i = 0; i < LINES; i++)
      if (m_vld[i] != 2'b00 && m_tag[i] == t) return i;
    return -1;
  endfunction

  // probe every word address with lookups on (or off) and compare all outputs
  task automatic sweep(input string req, input bit en);
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      logic [ADDR_W-1:0] ad;
      int ln, w;
      logic eh;
      logic [DATA_W-1:0] ew, e0, e1;
      logic [1:0] ev;
      ad = ADDR_W'(a);
      w = a & 1;
      lk_en = en; lk_addr = ad;
      #1;
      ln = find(ad[ADDR_W-1:1]);
      eh = en && ln >= 0 && m_vld[ln >= 0 ? ln : 0][w];
      ew = '0; e0 = '0; e1 = '0; ev = '0;
      if (eh) begin
        e0 = m_d0[ln]; e1 = m_d1[ln]; ev = m_vld[ln];
        ew = w ? e1 : e0;
      end
      total++;
      if (lk_hit !== eh || lk_word !== ew || lk_blk0 !== e0 || lk_blk1 !== e1 || lk_bvalid !== ev) begin
        bad++;
        $display("FAIL %s addr=%0d hit=%b/%b word=%h/%h blk=%h,%h/%h,%h vld=%b/%b",
                 req, a, lk_hit, eh, lk_word, ew, lk_blk0, lk_blk1, e0, e1, lk_bvalid, ev);
      end
    end
    lk_en = 0;
  endtask

  // one clocked operation; model follows the priority insert > remove > store
  task automatic op(input bit i_en, input int t, input logic [1:0] v,
                    input bit l_en, input logic [ADDR_W-1:0] la, input bit r_en,
                    input bit s_en, input logic [ADDR_W-1:0] sa, input logic [DATA_W-1:0] sd);
    int rl, sl, il;
    @(negedge clk);
    ins_en = i_en; ins_tag = TAG_W'(t); ins_wvalid = v;
    ins_word0 = pat(t, 0); ins_word1 = pat(t, 1);
    lk_en = l_en; lk_addr = la; rm_en = r_en;
    st_en = s_en; st_addr = sa; st_word = sd;
    rl = find(la[ADDR_W-1:1]);
    if (!(l_en && r_en && rl >= 0 && m_vld[rl >= 0 ? rl : 0][la[0]])) rl = -1;
    sl = s_en ? find(sa[ADDR_W-1:1]) : -1;
    il = i_en ? m_ptr : -1;
    @(posedge clk);
    #1;
    ins_en = 0; lk_en = 0; rm_en = 0; st_en = 0;
    for (int i = 0; i < LINES; i++) begin
      if (i == il) begin
        m_tag[i] = TAG_W'(t); m_vld[i] = v; m_d0[i] = pat(t, 0); m_d1[i] = pat(t, 1);
      end else if (i == rl) begin
        m_vld[i] = 2'b00;
      end else if (i == sl) begin
        if (sa[0]) m_d1[i] = sd; else m_d0[i] = sd;
        m_vld[i][sa[0]] = 1'b1;
      end
    end
    if (i_en) m_ptr = (m_ptr + 1) % LINES;
  endtask

  task automatic ins(input int t, input logic [1:0] v);
    op(1, t, v, 0, '0, 0, 0, '0, '0);
  endtask

  initial begin
    for (int i = 0; i < LINES; i++) begin
      m_tag[i] = '0; m_vld[i] = 2'b00; m_d0[i] = '0; m_d1[i] = '0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1 empty after reset", 1);
    // R3/R4/R2: fill all four lines with mixed valid patterns
    ins(3, 2'b11); ins(7, 2'b01); ins(9, 2'b10); ins(12, 2'b11);
    sweep("R3 R2 R5 after four inserts", 1);
    sweep("R9 lookup disabled", 0);
    // R4: fifth insert replaces oldest (tag 3)
    ins(5, 2'b11);
    sweep("R4 fifth insert evicts oldest", 1);
    // R6: removal on hit of tag 12 word 0
    op(0, 0, 2'b00, 1, ADDR_W'({4'd12, 1'b0}), 1, 0, '0, '0);
    sweep("R6 removal clears line", 1);
    // R6: removal while missing (tag 9 word 0 invalid) changes nothing
    op(0, 0, 2'b00, 1, ADDR_W'({4'd9, 1'b0}), 1, 0, '0, '0);
    sweep("R6 removal on miss ignored", 1);
    // R10: next insert lands on line 1 (tag 7) although line 3 is empty
    ins(14, 2'b01);
    sweep("R10 pointer skips emptied line", 1);
    // R7: store fills invalid word 0 of tag 9; store to absent tag ignored
    op(0, 0, 2'b00, 0, '0, 0, 1, ADDR_W'({4'd9, 1'b0}), 16'hBEEF);
    sweep("R7 store updates held word", 1);
    op(0, 0, 2'b00, 0, '0, 0, 1, ADDR_W'({4'd2, 1'b1}), 16'h1234);
    sweep("R7 store miss ignored", 1);
    // R8: insert to line 2 while removal and store hit line 2 (tag 9)
    op(1, 6, 2'b10, 1, ADDR_W'({4'd9, 1'b1}), 1, 1, ADDR_W'({4'd9, 1'b0}), 16'h5555);
    sweep("R8 insert wins collision", 1);
    // R4: wrap further, refill emptied line 3 then overwrite line 0
    ins(1, 2'b11); ins(8, 2'b10);
    sweep("R4 wrap and refill", 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule